// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block arbitrates between five hardware interrupt lines and software restart requests, then tells the sequencer where to restart. The lines are a non-maskable edge input (`trap_i`), three maskable fixed-vector inputs (`rst75_i`, `rst65_i` and `rst55_i`) and one vectored request (`intr_i`). On each clock it picks at most one winner. It then pulses `take_o` together with the 16-bit restart address on `vector_o`. The caller saves the program counter and jumps.

The vectored request goes through a one-cycle acknowledge. The block raises `inta_o`, and the device answers on `inta_opc_i` with a restart opcode. Opcode bits [5:3] pick the restart number. A mask write port loads the three line masks and can clear the edge latch of the highest maskable line. The status port returns the masks, the global enable and the pending state of every line. Global enable is set and cleared by the `ei_i` and `di_i` strobes.

Top module: `restart_irq_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, take_o and inta_o are 0, vector_o is 0000H, the global enable is 0 and all three masks are 1 (status_o = 07H with all lines low).
- R2: A rising edge on trap_i is taken on the next clock edge with vector 0024H, whatever the enable and masks are. A trap_i level held high gives exactly one take.
- R3: When several requests are eligible in the same cycle, the winner is the first in this order: trap_i, rst75_i, rst65_i, rst55_i, intr_i, then the software request.
- R4: rst75_i vectors to 003CH, rst65_i to 0034H and rst55_i to 002CH.
- R5: A rising edge on rst75_i is latched even if the pulse ends before it can be taken. The latch shows in status_o[6]. It clears when the line is taken, or on a mask write with mask_wdata_i[3]=1. It latches even while masked.
- R6: rst65_i and rst55_i are level requests: a level that falls before the enable returns is never taken.
- R7: rst75_i, rst65_i and rst55_i are taken only with the global enable set and their mask bit clear. The mask bits are mask_wdata_i[2] for rst75_i, [1] for rst65_i and [0] for rst55_i, where 1 blocks. intr_i needs only the global enable.
- R8: Accepting any maskable line or intr_i clears the global enable. ei_i sets it, di_i clears it, and di_i wins when both are high. A trap take leaves it unchanged.
- R9: An accepted intr_i raises inta_o for exactly one cycle with take_o low. At the next clock edge, take_o rises with vector 8 × inta_opc_i[5:3], and inta_o falls. No other source is taken during the acknowledge cycle.
- R10: sw_req_i is taken with vector 8 × sw_num_i only in a cycle when no hardware line wins and no acknowledge is in progress. A losing request is dropped. It ignores masks and enable and leaves the enable unchanged.
- R11: status_o is {trap pending, rst75 latch, rst65_i, rst55_i, enable, mask[2:0]}, from bit 7 down to bit 0. A mask write loads mask[2:0] from mask_wdata_i[2:0] at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable request, rising-edge sensitive |
| rst75_i | input | 1 | Maskable request, rising-edge latched, vector 003CH |
| rst65_i | input | 1 | Maskable level request, vector 0034H |
| rst55_i | input | 1 | Maskable level request, vector 002CH |
| intr_i | input | 1 | Vectored request needing an acknowledge |
| inta_opc_i | input | 8 | Restart opcode supplied during the acknowledge cycle |
| sw_req_i | input | 1 | Software restart request |
| sw_num_i | input | 3 | Software restart number |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | [2:0] mask bits, [3] clear rst75 latch |
| take_o | output | 1 | One-cycle take strobe |
| vector_o | output | 16 | Restart address, held between takes |
| inta_o | output | 1 | Interrupt acknowledge |
| status_o | output | 8 | Mask, enable and pending read-back |

## Verification
The bench pulses rst75_i for a single cycle while the line is masked or disabled. A design that sampled the level instead of latching the edge would lose that request. The bench holds trap_i high for several cycles, where a level-sensitive trap would restart repeatedly. It raises all lines at once, so a mis-ordered priority encoder shows up as the wrong vector. It also drops rst55_i before enabling, which a design that latched level lines would wrongly take. It collides a software request with a trap edge to confirm the loser is dropped. It sets ei_i and di_i together to confirm disable wins. It feeds an opcode during the acknowledge cycle and checks that nothing else slips in.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned VEC_W = 16;
  localparam int unsigned NSRC  = 5;

  typedef enum int unsigned {
    SRC_TRAP = 0,
    SRC_R75  = 1,
    SRC_R65  = 2,
    SRC_R55  = 3,
    SRC_INTR = 4
  } src_e;

  // restart address counted in half-slots of 4 bytes
  function automatic logic [VEC_W-1:0] rst_addr(input int unsigned half_slots);
    return VEC_W'(half_slots * 4);
  endfunction

  localparam int unsigned HS_TRAP = 9;
  localparam int unsigned HS_R75  = 15;
  localparam int unsigned HS_R65  = 13;
  localparam int unsigned HS_R55  = 11;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic clr_i,
  output logic req_o,
  output logic pend_o
);
  logic prev_q, pend_q, rise;

  assign rise = in_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= in_i;
      if (clr_i)     pend_q <= 1'b0;
      else if (rise) pend_q <= 1'b1;
    end
  end

  assign req_o  = pend_q | rise;
  assign pend_o = pend_q;

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_o);
  p_edge_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !clr_i) |=> pend_o);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  p_grant_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_top_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> gnt_o[0]);
endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_W   = 3,
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned OPC_LSB = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic             rst75_i,
  input  logic             rst65_i,
  input  logic             rst55_i,
  input  logic             intr_i,
  input  logic [OPC_W-1:0] inta_opc_i,
  input  logic             sw_req_i,
  input  logic [NUM_W-1:0] sw_num_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             mask_wr_i,
  input  logic [3:0]       mask_wdata_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             inta_o,
  output logic [7:0]       status_o
);
  logic             ack_q, ie_q;
  logic [2:0]       mask_q;
  logic             trap_req, trap_pend, r75_req, r75_pend, r75_clr;
  logic [NSRC-1:0]  req, gnt;
  logic             any_hw, sw_take, mi_take, take_d;
  logic [VEC_W-1:0] vec_d;

  irq_edge_latch u_trap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (trap_i),
    .clr_i  (gnt[SRC_TRAP]),
    .req_o  (trap_req),
    .pend_o (trap_pend)
  );

  assign r75_clr = gnt[SRC_R75] | (mask_wr_i & mask_wdata_i[3]);

  irq_edge_latch u_r75 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (rst75_i),
    .clr_i  (r75_clr),
    .req_o  (r75_req),
    .pend_o (r75_pend)
  );

  // nothing competes while an acknowledge is outstanding
  always_comb begin
    req = '0;
    if (!ack_q) begin
      req[SRC_TRAP] = trap_req;
      req[SRC_R75]  = ie_q & ~mask_q[2] & r75_req;
      req[SRC_R65]  = ie_q & ~mask_q[1] & rst65_i;
      req[SRC_R55]  = ie_q & ~mask_q[0] & rst55_i;
      req[SRC_INTR] = ie_q & intr_i;
    end
  end

  irq_prio_sel #(.N(NSRC)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .gnt_o  (gnt),
    .any_o  (any_hw)
  );

  assign sw_take = sw_req_i & ~any_hw & ~ack_q;
  assign mi_take = gnt[SRC_R75] | gnt[SRC_R65] | gnt[SRC_R55] | gnt[SRC_INTR];
  assign take_d  = ack_q | (any_hw & ~gnt[SRC_INTR]) | sw_take;

  always_comb begin
    vec_d = vector_o;
    if (ack_q)              vec_d = rst_addr(2 * int'(inta_opc_i[OPC_LSB +: NUM_W]));
    else if (gnt[SRC_TRAP]) vec_d = rst_addr(HS_TRAP);
    else if (gnt[SRC_R75])  vec_d = rst_addr(HS_R75);
    else if (gnt[SRC_R65])  vec_d = rst_addr(HS_R65);
    else if (gnt[SRC_R55])  vec_d = rst_addr(HS_R55);
    else if (sw_take)       vec_d = rst_addr(2 * int'(sw_num_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      take_o   <= 1'b0;
      vector_o <= '0;
      ie_q     <= 1'b0;
      mask_q   <= '1;
    end else begin
      ack_q    <= gnt[SRC_INTR];
      take_o   <= take_d;
      vector_o <= vec_d;
      if (mi_take | di_i) ie_q <= 1'b0;
      else if (ei_i)      ie_q <= 1'b1;
      if (mask_wr_i) mask_q <= mask_wdata_i[2:0];
    end
  end

  assign inta_o   = ack_q;
  assign status_o = {trap_pend, r75_pend, rst65_i, rst55_i, ie_q, mask_q};

  p_ack_then_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> (take_o && !inta_o));
  p_no_take_in_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> !take_o);
  p_take_clears_ie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mi_take |=> !status_o[3]);
  p_trap_vector_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt[SRC_TRAP] |=> (take_o && vector_o == 16'h0024));
  p_sw_keeps_ie_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_take && !ei_i && !di_i) |=> $stable(status_o[3]));
endmodule

// File: tb/restart_irq_ctrl_test.sv
module restart_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap = 0, rst75 = 0, rst65 = 0, rst55 = 0, intr = 0;
  logic [7:0] inta_opc = 8'h00;
  logic sw_req = 0;
  logic [2:0] sw_num = 3'd0;
  logic ei = 0, di = 0, mask_wr = 0;
  logic [3:0] mask_wdata = 4'h0;
  logic take, inta;
  logic [15:0] vector;
  logic [7:0] status;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  restart_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .trap_i(trap), .rst75_i(rst75), .rst65_i(rst65),
    .rst55_i(rst55), .intr_i(intr), .inta_opc_i(inta_opc), .sw_req_i(sw_req),
    .sw_num_i(sw_num), .ei_i(ei), .di_i(di), .mask_wr_i(mask_wr),
    .mask_wdata_i(mask_wdata), .take_o(take), .vector_o(vector), .inta_o(inta),
    .status_o(status)
  );

  // behavioural reference
  logic m_ie, m_l75, m_tp, m_pt, m_p75, m_ack, m_take;
  logic [2:0] m_mask;
  logic [15:0] m_vec;
  integer pick;
  bit te, e75, treq, r75q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_mask = 3'b111; m_l75 = 0; m_tp = 0; m_pt = 0; m_p75 = 0;
      m_ack = 0; m_take = 0; m_vec = 16'h0000;
    end else begin
      te = trap && !m_pt;
      e75 = rst75 && !m_p75;
      treq = m_tp || te;
      r75q = m_l75 || e75;
      pick = -1;
      if (!m_ack) begin
        if (treq) pick = 0;
        else if (m_ie && r75q && !m_mask[2]) pick = 1;
        else if (m_ie && rst65 && !m_mask[1]) pick = 2;
        else if (m_ie && rst55 && !m_mask[0]) pick = 3;
        else if (m_ie && intr) pick = 4;
        else if (sw_req) pick = 5;
      end
      m_take = m_ack || (pick >= 0 && pick != 4);
      if (m_ack) m_vec = 16'(inta_opc[5:3]) * 16'd8;
      else case (pick)
        0: m_vec = 16'h0024;
        1: m_vec = 16'h003C;
        2: m_vec = 16'h0034;
        3: m_vec = 16'h002C;
        5: m_vec = 16'(sw_num) * 16'd8;
        default: ;
      endcase
      m_ack = (pick == 4);
      if (pick == 0) m_tp = 0; else if (te) m_tp = 1;
      if (pick == 1 || (mask_wr && mask_wdata[3])) m_l75 = 0; else if (e75) m_l75 = 1;
      if (pick >= 1 && pick <= 4) m_ie = 0; else if (di) m_ie = 0; else if (ei) m_ie = 1;
      if (mask_wr) m_mask = mask_wdata[2:0];
      m_pt = trap;
      m_p75 = rst75;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(take === m_take, "R4 model take", 32'(take), 32'(m_take));
      check(vector === m_vec, "R4 model vector", 32'(vector), 32'(m_vec));
      check(inta === m_ack, "R9 model inta", 32'(inta), 32'(m_ack));
      check(status === {m_tp, m_l75, rst65, rst55, m_ie, m_mask}, "R11 model status",
            32'(status), 32'({m_tp, m_l75, rst65, rst55, m_ie, m_mask}));
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_take(input int maxc, output bit got, output logic [15:0] v);
    got = 0; v = 16'hxxxx;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (take === 1'b1) begin got = 1; v = vector; return; end
    end
  endtask

  task automatic enable_once();
    ei = 1; cyc(); ei = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    bit got;
    logic [15:0] v;
    cyc(3);
    // R1
    check(take === 0 && inta === 0, "R1 reset strobes", {take, inta}, 0);
    check(vector === 16'h0000, "R1 reset vector", vector, 16'h0000);
    check(status === 8'h07, "R1 reset status", status, 8'h07);
    rst_n = 1; cyc();
    check(status === 8'h07 && take === 0, "R1 after release", status, 8'h07);

    // R2 edge trap with everything masked/disabled
    trap = 1;
    wait_take(3, got, v);
    check(got && v === 16'h0024, "R2 trap vector", v, 16'h0024);
    for (int i = 0; i < 3; i++) begin
      cyc();
      check(take === 0, "R2 held level no retake", take, 0);
    end
    trap = 0;

    // R11 mask write, R8 enable
    mask_wr = 1; mask_wdata = 4'h0; cyc(); mask_wr = 0;
    check(status[2:0] === 3'b000, "R11 mask write", status[2:0], 0);
    enable_once();
    check(status[3] === 1, "R8 ei sets enable", status[3], 1);

    // R3 / R4 priority with all lines raised
    rst65 = 1; rst55 = 1; intr = 1; rst75 = 1; cyc(); rst75 = 0;
    check(take === 1 && vector === 16'h003C, "R3 rst75 wins", vector, 16'h003C);
    check(status[3] === 0, "R8 take clears enable", status[3], 0);
    for (int i = 0; i < 2; i++) begin
      cyc();
      check(take === 0, "R7 disabled blocks", take, 0);
    end
    enable_once();
    wait_take(3, got, v);
    check(got && v === 16'h0034, "R3 rst65 next", v, 16'h0034);
    rst65 = 0; enable_once();
    wait_take(3, got, v);
    check(got && v === 16'h002C, "R4 rst55 vector", v, 16'h002C);
    rst55 = 0; enable_once();
    cyc();
    check(inta === 1 && take === 0, "R9 inta raised", {inta, take}, 2'b10);
    inta_opc = 8'hEF; cyc();
    check(take === 1 && inta === 0 && vector === 16'h0028, "R9 opcode vector", vector, 16'h0028);
    intr = 0; inta_opc = 8'h00;

    // R6 level line dropped before enable
    rst55 = 1; cyc(); rst55 = 0; enable_once();
    for (int i = 0; i < 3; i++) begin
      cyc();
      check(take === 0, "R6 dropped level ignored", take, 0);
    end

    // R5 edge latch
    di = 1; cyc(); di = 0;
    rst75 = 1; cyc(); rst75 = 0; cyc();
    check(status[6] === 1 && take === 0, "R5 latch held", status[6], 1);
    enable_once();
    wait_take(3, got, v);
    check(got && v === 16'h003C, "R5 latched taken", v, 16'h003C);
    check(status[6] === 0, "R5 latch cleared by take", status[6], 0);
    rst75 = 1; cyc(); rst75 = 0;
    check(status[6] === 1, "R5 latch set again", status[6], 1);
    mask_wr = 1; mask_wdata = 4'h8; cyc(); mask_wr = 0;
    check(status[6] === 0, "R5 latch cleared by write", status[6], 0);

    // R7 masks block
    mask_wr = 1; mask_wdata = 4'h7; cyc(); mask_wr = 0;
    rst65 = 1; rst55 = 1; enable_once();
    rst75 = 1; cyc(); rst75 = 0;
    check(take === 0, "R7 masked rst75", take, 0);
    for (int i = 0; i < 2; i++) begin
      cyc();
      check(take === 0, "R7 masked levels", take, 0);
    end
    check(status === 8'h7F, "R7 status masked", status, 8'h7F);
    rst65 = 0; rst55 = 0;
    mask_wr = 1; mask_wdata = 4'hF; cyc(); mask_wr = 0;

    // R10 software restart
    sw_req = 1; sw_num = 3'd3; cyc(); sw_req = 0;
    check(take === 1 && vector === 16'h0018, "R10 sw vector", vector, 16'h0018);
    check(status[3] === 1, "R10 enable kept", status[3], 1);
    trap = 1; sw_req = 1; sw_num = 3'd5; cyc(); sw_req = 0;
    check(vector === 16'h0024, "R10 trap beats sw", vector, 16'h0024);
    cyc();
    check(take === 0, "R10 losing sw dropped", take, 0);
    trap = 0;

    // R8 disable wins
    ei = 1; di = 1; cyc(); ei = 0; di = 0;
    check(status[3] === 0, "R8 di wins", status[3], 0);

    cyc(3);
    finish_run();
  end
endmodule